// File: doc/BRIEF.md
# Threshold Offset Register Programmer

This block keeps the two threshold offsets that a FIFO's partial-fill flags compare against: one measured from the empty boundary and one measured from the full boundary. A single configuration pin plays two roles. While master reset is held, its level picks both the programming method (parallel or serial) and the default value loaded into both offsets. After reset, the same pin acts as the load strobe qualifier.

In parallel mode, a write-clock edge with the write enable and the configuration pin both high takes one offset from the low bits of the data-input bus. In serial mode, an edge with the serial enable and the configuration pin both high takes one bit from the serial input. On the read-clock side, an edge with the read enable and the configuration pin both high places one offset, zero-extended, on the data-output bus. Readback works in either mode.

Every access walks the same fixed sequence: the almost-empty offset first, then the almost-full offset, then back to the start. A partial reset returns both sequence pointers to the start and keeps the mode and both offset values. Flag comparison, storage and clock-domain crossing belong to the surrounding FIFO.

Top module: `offs_prog`

## Requirements
- R1: At a write-clock edge with `mst_rst` high, `ld_sel` low selects parallel mode and sets both offsets to `DEF_PAR`. `ld_sel` high selects serial mode and sets both offsets to `DEF_SER`.
- R2: In parallel mode, each write-clock edge with `wr_en` and `ld_sel` high stores `din[ADDR_W-1:0]` into the next offset of the sequence. The sequence is almost-empty, then almost-full, then wraps. Upper `din` bits are dropped.
- R3: In serial mode, each write-clock edge with `ser_en` and `ld_sel` high stores `ser_in` into the next bit. The first `ADDR_W` bits fill the almost-empty offset LSB first, the next `ADDR_W` bits fill the almost-full offset LSB first, and then the sequence wraps.
- R4: Serial strobes have no effect in parallel mode, and parallel strobes have no effect in serial mode. Strobes with `ld_sel` low have no effect in either mode.
- R5: Each read-clock edge with `rd_en` and `ld_sel` high registers the next offset of the sequence onto `dout`, zero-extended. The sequence is almost-empty, then almost-full, then wraps. This works in both modes.
- R6: `dout` holds its value on read-clock edges without a readback strobe.
- R7: Partial reset keeps the mode and both offset values, returns the write and read sequence pointers to the almost-empty offset (also in the middle of a serial word), and clears `dout`.
- R8: Master reset also returns both sequence pointers to the start and clears `dout`. When both resets are high, master reset takes precedence.
- R9: Loading one offset leaves the other offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mst_rst | input | 1 | Master reset, synchronous, active high, seen by both clocks |
| part_rst | input | 1 | Partial reset, synchronous, active high, seen by both clocks |
| ld_sel | input | 1 | Configuration select during master reset, load qualifier otherwise |
| wr_en | input | 1 | Parallel load strobe |
| ser_en | input | 1 | Serial load strobe |
| ser_in | input | 1 | Serial data bit |
| din | input | DATA_W | Parallel load data |
| rd_en | input | 1 | Readback strobe |
| dout | output | DATA_W | Readback data |
| ae_off | output | ADDR_W | Current almost-empty offset |
| af_off | output | ADDR_W | Current almost-full offset |

## Verification
The bench builds the block with `ADDR_W` = 12 and `DATA_W` = 16, and keeps the default values 127 and 1023. With this width, a serial word is only twelve bits long, so the bench can run complete serial sequences, their wrap, and an interrupted word within a few hundred cycles. The gap between the two widths lets the bench check that upper `din` bits are dropped and that readback data is zero-extended. Both defaults also fit the register, so the bench checks both reset configurations exactly.

// File: rtl/offs_pkg.sv
package offs_pkg;
    typedef enum logic {
        PGM_PAR = 1'b0,
        PGM_SER = 1'b1
    } pgm_mode_e;
endpackage

// File: rtl/offs_wr_ctrl.sv
module offs_wr_ctrl
    import offs_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 18,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023
) (
    input  logic              wr_clk,
    input  logic              mst_rst,
    input  logic              part_rst,
    input  logic              ld_sel,
    input  logic              wr_en,
    input  logic              ser_en,
    input  logic              ser_in,
    input  logic [DATA_W-1:0] din,
    output logic [ADDR_W-1:0] ae_off,
    output logic [ADDR_W-1:0] af_off
);
    localparam int CNT_W = $clog2(2 * ADDR_W);
    localparam int IDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * ADDR_W - 1);
    localparam logic [ADDR_W-1:0] DEF_PAR_V = ADDR_W'(DEF_PAR);
    localparam logic [ADDR_W-1:0] DEF_SER_V = ADDR_W'(DEF_SER);

    typedef struct packed {
        pgm_mode_e         mode;
        logic [ADDR_W-1:0] ae;
        logic [ADDR_W-1:0] af;
        logic              wsel;   // parallel pointer: 0 = almost-empty next
        logic [CNT_W-1:0]  scnt;   // serial bit pointer over both offsets
    } wst_t;

    wst_t q, d;
    logic par_hit, ser_hit;
    logic [CNT_W-1:0] bpos;
    logic [IDX_W-1:0] bidx;

    generate
        if (DATA_W > ADDR_W) begin : g_sink
            logic unused_din_hi;
            assign unused_din_hi = ^din[DATA_W-1:ADDR_W];
        end
    endgenerate

    always_comb begin
        d       = q;
        par_hit = wr_en  && ld_sel && (q.mode == PGM_PAR);
        ser_hit = ser_en && ld_sel && (q.mode == PGM_SER);
        bpos    = (q.scnt < CNT_HALF) ? q.scnt : (q.scnt - CNT_HALF);
        bidx    = IDX_W'(bpos);
        if (mst_rst) begin
            d.mode = ld_sel ? PGM_SER : PGM_PAR;
            d.ae   = ld_sel ? DEF_SER_V : DEF_PAR_V;
            d.af   = ld_sel ? DEF_SER_V : DEF_PAR_V;
            d.wsel = 1'b0;
            d.scnt = '0;
        end else if (part_rst) begin
            d.wsel = 1'b0;
            d.scnt = '0;
        end else if (par_hit) begin
            if (!q.wsel) d.ae = din[ADDR_W-1:0];
            else         d.af = din[ADDR_W-1:0];
            d.wsel = ~q.wsel;
        end else if (ser_hit) begin
            if (q.scnt < CNT_HALF) d.ae[bidx] = ser_in;
            else                   d.af[bidx] = ser_in;
            d.scnt = (q.scnt == CNT_LAST) ? '0 : q.scnt + 1'b1;
        end
    end

    always_ff @(posedge wr_clk) begin
        q <= d;
    end

    assign ae_off = q.ae;
    assign af_off = q.af;

    assert_mst_default_R1: assert property (@(posedge wr_clk) disable iff (part_rst)
        mst_rst |=> (ae_off == ($past(ld_sel) ? DEF_SER_V : DEF_PAR_V))
                 && (af_off == ae_off));

    assert_par_first_R2: assert property (@(posedge wr_clk) disable iff (mst_rst || part_rst)
        (wr_en && ld_sel && q.mode == PGM_PAR && !q.wsel)
        |=> (ae_off == $past(din[ADDR_W-1:0])) && $stable(af_off));

    assert_ser_first_bit_R3: assert property (@(posedge wr_clk) disable iff (mst_rst || part_rst)
        (ser_en && ld_sel && q.mode == PGM_SER && q.scnt == '0)
        |=> (ae_off[0] == $past(ser_in)) && $stable(af_off));

    assert_ser_ignores_par_R4: assert property (@(posedge wr_clk) disable iff (mst_rst || part_rst)
        (q.mode == PGM_SER && !ser_en) |=> $stable(ae_off) && $stable(af_off));

    assert_part_keeps_R7: assert property (@(posedge wr_clk) disable iff (mst_rst)
        part_rst |=> $stable(ae_off) && $stable(af_off) && $stable(q.mode));
endmodule

// File: rtl/offs_rd_port.sv
module offs_rd_port #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 18
) (
    input  logic              rd_clk,
    input  logic              mst_rst,
    input  logic              part_rst,
    input  logic              ld_sel,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] ae_in,
    input  logic [ADDR_W-1:0] af_in,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic              rsel;   // 0 = almost-empty next
        logic [DATA_W-1:0] dout;
    } rst_t;

    rst_t q, d;

    always_comb begin
        d = q;
        if (mst_rst || part_rst) begin
            d.rsel = 1'b0;
            d.dout = '0;
        end else if (rd_en && ld_sel) begin
            d.dout = '0;
            d.dout[ADDR_W-1:0] = q.rsel ? af_in : ae_in;
            d.rsel = ~q.rsel;
        end
    end

    always_ff @(posedge rd_clk) begin
        q <= d;
    end

    assign dout = q.dout;

    assert_rd_first_R5: assert property (@(posedge rd_clk) disable iff (mst_rst || part_rst)
        (rd_en && ld_sel && !q.rsel) |=> (dout == DATA_W'($past(ae_in))));

    assert_rd_hold_R6: assert property (@(posedge rd_clk) disable iff (mst_rst || part_rst)
        !(rd_en && ld_sel) |=> $stable(dout));

    assert_rst_clear_R8: assert property (@(posedge rd_clk)
        disable iff (!(mst_rst || part_rst))
        (mst_rst || part_rst) |=> (dout == '0));
endmodule

// File: rtl/offs_prog.sv
module offs_prog #(
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 18,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mst_rst,
    input  logic              part_rst,
    input  logic              ld_sel,
    input  logic              wr_en,
    input  logic              ser_en,
    input  logic              ser_in,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en,
    output logic [DATA_W-1:0] dout,
    output logic [ADDR_W-1:0] ae_off,
    output logic [ADDR_W-1:0] af_off
);
    offs_wr_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)
    ) u_wr (
        .wr_clk(wr_clk), .mst_rst(mst_rst), .part_rst(part_rst), .ld_sel(ld_sel),
        .wr_en(wr_en), .ser_en(ser_en), .ser_in(ser_in), .din(din),
        .ae_off(ae_off), .af_off(af_off)
    );

    offs_rd_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_rd (
        .rd_clk(rd_clk), .mst_rst(mst_rst), .part_rst(part_rst), .ld_sel(ld_sel),
        .rd_en(rd_en), .ae_in(ae_off), .af_in(af_off), .dout(dout)
    );
endmodule

// File: tb/sim_offs_prog.sv
`timescale 1ns/1ps
module sim_offs_prog;
    localparam int AW = 12;
    localparam int DW = 16;

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic mst_rst = 1'b1, part_rst = 1'b0, ld_sel = 1'b0;
    logic wr_en = 1'b0, ser_en = 1'b0, ser_in = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic [AW-1:0] ae_off, af_off;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [DW-1:0] exp_q[$];
    string tag_q[$];

    offs_prog #(.ADDR_W(AW), .DATA_W(DW), .DEF_PAR(127), .DEF_SER(1023)) u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mst_rst(mst_rst), .part_rst(part_rst),
        .ld_sel(ld_sel), .wr_en(wr_en), .ser_en(ser_en), .ser_in(ser_in), .din(din),
        .rd_en(rd_en), .dout(dout), .ae_off(ae_off), .af_off(af_off)
    );

    always #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5 rd_clk = ~rd_clk;
    end

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares readback data against the scoreboard queue
    initial begin
        forever begin
            bit fire;
            @(posedge rd_clk);
            fire = rd_en && ld_sel && !mst_rst && !part_rst;
            @(negedge rd_clk);
            if (fire) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R5 actual=%0h expected=none", dout);
                end else begin
                    logic [DW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, dout, e);
                end
            end
        end
    end

    task automatic do_mrst(logic cfg, logic with_part);
        @(negedge wr_clk);
        mst_rst = 1'b1; part_rst = with_part; ld_sel = cfg;
        repeat (3) @(negedge wr_clk);
        mst_rst = 1'b0; part_rst = 1'b0; ld_sel = 1'b0;
    endtask

    task automatic do_prst();
        @(negedge wr_clk);
        part_rst = 1'b1;
        repeat (3) @(negedge wr_clk);
        part_rst = 1'b0;
    endtask

    task automatic par_wr(logic [DW-1:0] v, logic with_ld);
        @(negedge wr_clk);
        wr_en = 1'b1; ld_sel = with_ld; din = v;
        @(negedge wr_clk);
        wr_en = 1'b0; ld_sel = 1'b0;
    endtask

    task automatic ser_bits(logic [AW-1:0] v, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            ser_en = 1'b1; ld_sel = 1'b1; ser_in = v[i];
        end
        @(negedge wr_clk);
        ser_en = 1'b0; ld_sel = 1'b0; ser_in = 1'b0;
    endtask

    // driver: one readback strobe, expected value pushed to the scoreboard
    task automatic rb(logic [DW-1:0] e, string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge wr_clk);
        rd_en = 1'b1; ld_sel = 1'b1;
        @(negedge wr_clk);
        rd_en = 1'b0; ld_sel = 1'b0;
        @(negedge wr_clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 / R8: master reset, parallel configuration
        do_mrst(1'b0, 1'b0);
        @(negedge wr_clk);
        chk("R1 ae default par", DW'(ae_off), 16'd127);
        chk("R1 af default par", DW'(af_off), 16'd127);
        chk("R8 dout cleared", dout, 16'h0000);

        // R2 / R9: parallel sequence with wrap, upper din bits dropped
        par_wr(16'h00AB, 1'b1);
        chk("R2 ae loaded", DW'(ae_off), 16'h00AB);
        chk("R9 af untouched", DW'(af_off), 16'd127);
        par_wr(16'hF3CD, 1'b1);
        chk("R2 af loaded", DW'(af_off), 16'h03CD);
        chk("R9 ae untouched", DW'(ae_off), 16'h00AB);
        par_wr(16'h0055, 1'b1);
        chk("R2 wrap to ae", DW'(ae_off), 16'h0055);

        // R4: serial strobes in parallel mode, strobes without ld_sel
        ser_bits(12'hFFF, 5);
        par_wr(16'h0777, 1'b0);
        chk("R4 ae ignored", DW'(ae_off), 16'h0055);
        chk("R4 af ignored", DW'(af_off), 16'h03CD);
        par_wr(16'h0666, 1'b1);
        chk("R4 seq kept", DW'(af_off), 16'h0666);

        // R5 / R6: readback sequence and hold
        rb(16'h0055, "R5 rb ae");
        rb(16'h0666, "R5 rb af");
        rb(16'h0055, "R5 rb wrap");
        repeat (4) @(negedge wr_clk);
        chk("R6 dout holds", dout, 16'h0055);

        // R7: partial reset mid-sequence
        par_wr(16'h0111, 1'b1);
        rb(16'h0666, "R5 rb af again");
        do_prst();
        @(negedge wr_clk);
        chk("R7 ae kept", DW'(ae_off), 16'h0111);
        chk("R7 af kept", DW'(af_off), 16'h0666);
        chk("R7 dout cleared", dout, 16'h0000);
        par_wr(16'h0222, 1'b1);
        chk("R7 wr ptr to ae", DW'(ae_off), 16'h0222);
        chk("R7 mode kept", DW'(af_off), 16'h0666);
        rb(16'h0222, "R7 rd ptr to ae");

        // R1: master reset, serial configuration
        do_mrst(1'b1, 1'b0);
        @(negedge wr_clk);
        chk("R1 ae default ser", DW'(ae_off), 16'd1023);
        chk("R1 af default ser", DW'(af_off), 16'd1023);
        chk("R8 dout cleared ser", dout, 16'h0000);
        par_wr(16'h0ABC, 1'b1);
        chk("R4 par ignored ser", DW'(ae_off), 16'd1023);

        // R3 / R9: serial words, LSB first
        ser_bits(12'hA5C, AW);
        chk("R3 ae serial", DW'(ae_off), 16'h0A5C);
        chk("R9 af untouched ser", DW'(af_off), 16'd1023);
        ser_bits(12'h5A3, AW);
        chk("R3 af serial", DW'(af_off), 16'h05A3);
        chk("R9 ae untouched ser", DW'(ae_off), 16'h0A5C);
        ser_bits(12'h01F, 5);
        chk("R3 wrap partial", DW'(ae_off), 16'h0A5F);

        // R7: partial reset in the middle of a serial word
        do_prst();
        ser_bits(12'h0F0, AW);
        chk("R7 ser ptr to ae", DW'(ae_off), 16'h00F0);
        chk("R7 af kept ser", DW'(af_off), 16'h05A3);
        rb(16'h00F0, "R5 rb ae ser");
        rb(16'h05A3, "R5 rb af ser");

        // R8: master reset wins over partial reset
        do_mrst(1'b0, 1'b1);
        @(negedge wr_clk);
        chk("R8 mst over part", DW'(ae_off), 16'd127);
        par_wr(16'h0777, 1'b1);
        chk("R8 par mode back", DW'(ae_off), 16'h0777);

        repeat (3) @(negedge wr_clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R5 actual=%0d expected=0 pending", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule